// File: doc/BRIEF.md
# Codec Bit-Clock Presence Detector

This block tells software whether an external codec drives the serial bit clock of the shared audio link. The bit clock is asynchronous to the system clock. The block passes it through a flop synchronizer and counts its rising edges inside a repeating timeout window. It reports the result in an active-low status bit: 1 means no clock has been seen, and 0 means a codec is toggling the bit clock.

Software uses one 8-bit control byte. It writes it with a single-cycle strobe and reads it back at any time. To get a valid answer, software first sets the clear bit, then writes the enable bit with clear low, waits, and then drops enable so that the result stays latched. The same byte holds the link mode select bit, which picks between the AC'97 and HD Audio signal modes on the shared pins.

Top module: `bclk_presence_det`

## Requirements
- R1: After reset, `rd_data` reads 8'h02: mode 0, no-clock flag 1, enable 0, clear 0. `link_hda_mode` is 0.
- R2: Bit 0 is the link mode select. A write stores it, `rd_data[0]` returns it, and `link_hda_mode` follows it. The value 0 selects AC'97 signalling and 1 selects HD Audio signalling.
- R3: While the clear bit (bit 3) is 1, the no-clock flag (bit 1) reads 1 from the cycle after the clear bit is set. This holds even when enable is also 1.
- R4: With enable (bit 2) at 1 and clear at 0, the flag drops to 0 once EDGES_NEEDED synchronized rising edges of `bit_clk_in` occur within one window of WINDOW_CYCLES system clocks.
- R5: The flag stays at 1 when fewer than EDGES_NEEDED rising edges fall within every window. Examples are a slow bit clock, a stopped bit clock, or a single glitch. The edge count restarts at every window expiry.
- R6: While enable is 0 and clear is 0, the flag holds its value no matter what `bit_clk_in` does.
- R7: Bits 7:4 always read 0. Writes to bit 1 and to bits 7:4 have no effect.
- R8: The flag can change from 1 to 0 only in a cycle after enable read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bit_clk_in | input | 1 | Asynchronous codec bit clock |
| wr_en | input | 1 | Single-cycle write strobe for the control byte |
| wr_data | input | 8 | Write data: bit 0 mode, bit 2 enable, bit 3 clear |
| rd_data | output | 8 | Readback: bit 0 mode, bit 1 no-clock flag, bit 2 enable, bit 3 clear, 7:4 zero |
| link_hda_mode | output | 1 | Link signal mode: 0 AC'97, 1 HD Audio |

## Verification
The bench builds the block with EDGES_NEEDED = 4 and WINDOW_CYCLES = 32, keeping the two-stage synchronizer. With this short window, a bit clock with a rise period of 7 system clocks or less must be found, and one with a period of 11 or more can never reach four edges in one window. Random periods are drawn from both sides of that margin. A single three-cycle glitch and a stopped clock check that the edge count restarts. Directed writes cover clear-over-enable priority, freezing with enable low, and the read-only bits.

// File: rtl/bcd_pkg.sv
// Shared bit positions of the detector's control byte.
// Assumes an 8-bit control byte; positions are fixed because software decodes them.
package bcd_pkg;
    localparam int CTL_W     = 8;
    localparam int MODE_BIT  = 0;
    localparam int FLAG_BIT  = 1;
    localparam int EN_BIT    = 2;
    localparam int CLR_BIT   = 3;
endpackage

// File: rtl/bcd_sync.sv
// Synchronizes an asynchronous clock-like input and emits a one-cycle pulse on
// each synchronized rising edge.
// Assumes STAGES >= 2 and that the input toggles slower than clk/2.
module bcd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // First stage captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    // Keep the last synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/bcd_window.sv
// Counts synchronized edges inside a repeating timeout window and signals a
// hit when EDGES edges fall in one window.
// Assumes EDGES >= 2 (one glitch never detects) and WINDOW >= 2.
module bcd_window #(
    parameter int EDGES  = 4,
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise,
    output logic hit
);
    localparam int EW = (EDGES > 1) ? $clog2(EDGES) : 1;
    localparam int WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [EW-1:0] EDGE_LAST = EW'(EDGES - 1);
    localparam logic [WW-1:0] WIN_LAST  = WW'(WINDOW - 1);

    logic [EW-1:0] edge_cnt;
    logic [WW-1:0] win_cnt;
    logic          win_end;

    assign win_end = (win_cnt == WIN_LAST);
    assign hit     = run && rise && (edge_cnt == EDGE_LAST);

    // Advance the window timer; it restarts on expiry or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) win_cnt <= '0;
        else if (win_end)   win_cnt <= '0;
        else                win_cnt <= win_cnt + 1'b1;
    end

    // Count edges in the current window, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)                    edge_cnt <= '0;
        else if (win_end)                      edge_cnt <= '0;
        else if (rise && edge_cnt != EDGE_LAST) edge_cnt <= edge_cnt + 1'b1;
    end
endmodule

// File: rtl/bcd_csr.sv
// Holds the control byte (mode, enable, clear) and the active-low no-clock flag.
// Assumes the write strobe lasts one cycle per write; bit 1 and 7:4 are not writable.
module bcd_csr
    import bcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             hit,
    output logic [CTL_W-1:0] rd_data,
    output logic             run,
    output logic             mode
);
    logic en_q, clr_q, flag_n_q;

    // Store the writable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= 1'b0;
            en_q  <= 1'b0;
            clr_q <= 1'b0;
        end else if (wr_en) begin
            mode  <= wr_data[MODE_BIT];
            en_q  <= wr_data[EN_BIT];
            clr_q <= wr_data[CLR_BIT];
        end
    end

    // Update the flag: clear wins, a hit under enable detects, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_n_q <= 1'b1;
        else if (clr_q)      flag_n_q <= 1'b1;
        else if (en_q && hit) flag_n_q <= 1'b0;
    end

    assign run = en_q & ~clr_q;

    // Assemble the readback byte.
    always_comb begin
        rd_data           = '0;
        rd_data[MODE_BIT] = mode;
        rd_data[FLAG_BIT] = flag_n_q;
        rd_data[EN_BIT]   = en_q;
        rd_data[CLR_BIT]  = clr_q;
    end
endmodule

// File: rtl/bclk_presence_det.sv
// Top of the codec bit-clock presence detector: synchronizer, edge window and
// control byte. Assumes rst_n is the power-on reset and bit_clk_in is asynchronous.
module bclk_presence_det #(
    parameter int SYNC_STAGES   = 2,
    parameter int EDGES_NEEDED  = 4,
    parameter int WINDOW_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_clk_in,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       link_hda_mode
);
    logic rise, run, hit;

    bcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(bit_clk_in), .rise(rise)
    );

    bcd_window #(.EDGES(EDGES_NEEDED), .WINDOW(WINDOW_CYCLES)) u_win (
        .clk(clk), .rst_n(rst_n), .run(run), .rise(rise), .hit(hit)
    );

    bcd_csr u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hit(hit), .rd_data(rd_data), .run(run), .mode(link_hda_mode)
    );
endmodule

// File: rtl/bcd_checker.sv
// Temporal checks on the detector's readback byte, bound to every instance of the top.
module bcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data
);
    // Clear bit set -> flag reads "no clock" next cycle.
    assert_clear_forces_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |=> rd_data[1]);

    // Enable and clear both low -> flag frozen.
    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[2] && !rd_data[3]) |=> $stable(rd_data[1]));

    // Reserved bits read zero.
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:4] == 4'h0);

    // A detection only follows a cycle with enable set.
    assert_detect_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[1]) |-> $past(rd_data[2]));
endmodule

bind bclk_presence_det bcd_checker u_chk (.clk(clk), .rst_n(rst_n), .rd_data(rd_data));

// File: tb/sim_bclk_presence_det.sv
module sim_bclk_presence_det;
    localparam int CLK_P = 10;
    localparam int EDGES = 4;
    localparam int WIN   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bc = 1'b0;
    logic       glitch = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       link_hda_mode;
    int         bc_p = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    bclk_presence_det #(.SYNC_STAGES(2), .EDGES_NEEDED(EDGES), .WINDOW_CYCLES(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_clk_in(bc | glitch), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .link_hda_mode(link_hda_mode)
    );

    always #(CLK_P/2) clk = ~clk;

    // Bit clock: rise period bc_p system clocks, stopped low when 0.
    always begin
        if (bc_p == 0) begin
            bc = 1'b0;
            #(CLK_P + 3);
        end else begin
            #(bc_p * CLK_P / 2 + 1) bc = ~bc;
        end
    end

    function automatic logic exp_flag_n(int p);
        // Safe margins only: p*EDGES < WIN detects, p*(EDGES-1) >= WIN cannot.
        return (p * EDGES < WIN) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(logic [7:0] act, logic [7:0] exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * CLK_P);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(rd_data, 8'h02, "R1 reset byte");
        chk({7'd0, link_hda_mode}, 8'h00, "R1 mode output");

        // R2 mode bit
        wr(8'h01);
        chk({7'd0, link_hda_mode}, 8'h01, "R2 mode set");
        chk(rd_data, 8'h03, "R2 readback");
        wr(8'h00);
        chk({7'd0, link_hda_mode}, 8'h00, "R2 mode clear");

        // R7 reserved and flag bits not writable
        wr(8'hF2);
        chk(rd_data, 8'h02, "R7 reserved ignored");

        // R5 stopped clock and single glitch
        wr(8'h08); idle(2);
        wr(8'h04);
        idle(100);
        chk({7'd0, rd_data[1]}, 8'h01, "R5 stopped clock");
        @(negedge clk); glitch = 1'b1; idle(3); glitch = 1'b0;
        idle(100);
        chk({7'd0, rd_data[1]}, 8'h01, "R5 single glitch");

        // R3 clear wins over enable with a fast clock
        bc_p = 4;
        wr(8'h0C);
        idle(120);
        chk({7'd0, rd_data[1]}, 8'h01, "R3 clear over enable");

        // R4 then R3 clear with enable low after detection
        wr(8'h04);
        idle(120);
        chk({7'd0, rd_data[1]}, 8'h00, "R4 fast detect");
        wr(8'h02);
        chk({7'd0, rd_data[1]}, 8'h00, "R7 flag write ignored");
        wr(8'h08);
        idle(1);
        chk({7'd0, rd_data[1]}, 8'h01, "R3 clear after detect");
        wr(8'h00);

        // Random trials mixing both sides of the margin
        for (int t = 0; t < 12; t++) begin
            automatic int p = ($urandom % 2) ? (2 + $urandom % 6) : (11 + $urandom % 10);
            automatic logic m = 1'($urandom % 2);
            automatic logic e = exp_flag_n(p);
            bc_p = 0;
            wr({7'd0, m} | 8'h08);
            idle(2);
            chk({7'd0, rd_data[1]}, 8'h01, "R3 clear before run");
            bc_p = p;
            wr({7'd0, m} | 8'h04);
            idle(150);
            chk({7'd0, rd_data[1]}, {7'd0, e}, e ? "R5 slow clock" : "R4 random detect");
            wr({7'd0, m});
            bc_p = e ? 3 : 0;
            idle(120);
            chk({7'd0, rd_data[1]}, {7'd0, e}, "R6 freeze");
            chk({7'd0, link_hda_mode}, {7'd0, m}, "R2 mode kept");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule